// File: doc/BRIEF.md
# Interruptible Word Block-Move Engine

This block copies a run of 16-bit words from one region of a byte-addressed 24-bit memory space to another. A host first loads a 64-bit pointer register and a 16-bit count register, then pulses `start`. The pointer register holds two pointers. The source pointer sits in the low 32-bit half and the destination pointer in the high half. Only the low 24 bits of each half form an address.

The engine makes one transfer at a time over a simple memory master port. Each transfer is one read followed by one write, each with a valid/ready handshake. Read data returns on a separate valid strobe. After every transfer both pointers step by two bytes and are written back into the pointer register.

The count register is left alone during a normal run. An internal working counter does the counting. The count register changes only when the interrupt-request input stops a move between two transfers. At that point it receives the number of transfers still to be made, so a later `start` resumes the move where it stopped. Software must reload the count before every new move. The source and destination regions are assumed not to overlap.

Top module: `wordmove_engine`

## Requirements
- R1: The source byte address is `ptr_q[23:0]` and the destination byte address is `ptr_q[55:32]`. Bits 31:24 and 63:56 of `ptr_q` always read zero, whatever the host writes into them.
- R2: A `start` pulse taken while idle with `cnt_q` = N > 0 makes exactly N transfers. Then `done` is high for exactly one cycle, `busy` falls in that same cycle, and `intr` stays low.
- R3: Each transfer reads the word at the current source address and writes that same data to the current destination address.
- R4: Each transfer is one read request followed by one write request. `rd_valid` is held, with a stable address, until `rd_ready`. `wr_valid` rises only in the cycle after `rd_data_valid`.
- R5: In the cycle after each write handshake, both pointer fields in `ptr_q` have advanced by 2, modulo 2^24.
- R6: `cnt_q` keeps its loaded value through a move that runs to completion.
- R7: A `start` taken while idle with `cnt_q` = 0 raises `done` for one cycle in the next cycle. It issues no memory request and `busy` stays low.
- R8: `irq` is sampled only in the cycle of a write handshake. If `irq` is high and transfers remain, the engine stops: in the next cycle `intr` is high for one cycle, `busy` is low, and `cnt_q` holds the number of remaining transfers. If that write ended the last transfer, the move completes normally (R2, R6). A transfer already started is always finished.
- R9: A `start` after an interrupt resumes from the stored pointers and remaining count, and it completes the rest of the move.
- R10: While `busy` is high, `start`, `ptr_we` and `cnt_we` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ptr_we | input | 1 | Host write strobe for the pointer register |
| ptr_wdata | input | 64 | Pointer register write value |
| cnt_we | input | 1 | Host write strobe for the count register |
| cnt_wdata | input | 16 | Count register write value |
| start | input | 1 | Begin or resume a move |
| irq | input | 1 | Interrupt request, sampled between transfers |
| ptr_q | output | 64 | Pointer register contents |
| cnt_q | output | 16 | Count register contents |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle pulse on normal completion |
| intr | output | 1 | One-cycle pulse when an interrupt stops the move |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | 24 | Read byte address |
| rd_data_valid | input | 1 | Read data strobe |
| rd_data | input | 16 | Read data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 24 | Write byte address |
| wr_data | output | 16 | Write data |

## Verification
The bench sweeps transfer counts from one to six, with and without memory stalls. After each run it checks every destination word, the final pointers and the count that was left behind. An engine that also decremented `cnt_q` in a normal run would leave zero instead of N. An engine that ignored the 24-bit wrap would carry into bit 24 when a source run crosses address zero.

The bench holds `irq` high for a whole four-word move. The engine must stop after each single transfer and store 3, 2 and then 1. On the last transfer `done` must win over `intr`. An engine that checked `irq` before the first transfer, or that let `irq` beat the final transfer, would show a wrong pulse or count.

Further runs cover a zero count, which must give `done` at once and no memory traffic. They also cover `start` and register writes made in the middle of a move, which must not disturb the move.

// File: rtl/wm_pkg.sv
package wm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RD_REQ,
      ST_RD_WAIT,
      ST_WR
   } wm_state_e;
endpackage

// File: rtl/wm_ptr_half.sv
// One pointer field: stores the address bits only, pads to the half width
// with zeros, loads from the host and advances by STEP with wrap.
module wm_ptr_half #(
   parameter int HALF_W = 32,
   parameter int ADDR_W = 24,
   parameter int STEP   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              adv_en,
   output logic [HALF_W-1:0] q
);
   logic [ADDR_W-1:0] addr_q;

   initial begin
      assert (ADDR_W <= HALF_W) else $error("wm_ptr_half: ADDR_W exceeds HALF_W");
      assert (STEP > 0) else $error("wm_ptr_half: STEP must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr_q <= '0;
      else if (adv_en)  addr_q <= addr_q + ADDR_W'(STEP);
      else if (load_en) addr_q <= load_val;
   end

   generate
      if (ADDR_W == HALF_W) begin : g_full
         assign q = addr_q;
      end else begin : g_pad
         assign q = {{(HALF_W-ADDR_W){1'b0}}, addr_q};
      end
   endgenerate

   // R5: one step per transfer, wrapping inside the address width
   assert_adv_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      adv_en |=> addr_q == $past(addr_q) + ADDR_W'(STEP));
endmodule

// File: rtl/wm_cnt_reg.sv
// Count register: host load while idle, save of remaining count on interrupt.
module wm_cnt_reg #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [CNT_W-1:0] load_val,
   input  logic             save_en,
   input  logic [CNT_W-1:0] save_val,
   output logic [CNT_W-1:0] q
);
   initial begin
      assert (CNT_W >= 2) else $error("wm_cnt_reg: CNT_W too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (save_en) q <= save_val;
      else if (load_en) q <= load_val;
   end
endmodule

// File: rtl/wm_ctrl.sv
// Transfer sequencer: read request, read data, write, then advance/stop.
module wm_ctrl
   import wm_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              irq_i,
   input  logic [CNT_W-1:0]  cnt_i,
   output logic              rd_valid_o,
   input  logic              rd_ready_i,
   input  logic              rd_data_valid_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic              wr_valid_o,
   input  logic              wr_ready_i,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              adv_o,
   output logic              save_en_o,
   output logic [CNT_W-1:0]  save_val_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              intr_o
);
   wm_state_e         state_q;
   logic [CNT_W-1:0]  work_q;
   logic [DATA_W-1:0] rbuf_q;
   logic              done_q;
   logic              intr_q;
   logic              wr_fire;
   logic              last_xfer;

   assign wr_fire    = (state_q == ST_WR) && wr_ready_i;
   assign last_xfer  = (work_q == CNT_W'(1));
   assign adv_o      = wr_fire;
   assign save_en_o  = wr_fire && !last_xfer && irq_i;
   assign save_val_o = work_q - CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         work_q  <= '0;
         rbuf_q  <= '0;
         done_q  <= 1'b0;
         intr_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         intr_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  if (cnt_i == '0) begin
                     done_q <= 1'b1;
                  end else begin
                     work_q  <= cnt_i;
                     state_q <= ST_RD_REQ;
                  end
               end
            end
            ST_RD_REQ: begin
               if (rd_ready_i) state_q <= ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
               if (rd_data_valid_i) begin
                  rbuf_q  <= rd_data_i;
                  state_q <= ST_WR;
               end
            end
            ST_WR: begin
               if (wr_ready_i) begin
                  work_q <= work_q - CNT_W'(1);
                  if (last_xfer) begin
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else if (irq_i) begin
                     intr_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     state_q <= ST_RD_REQ;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rd_valid_o = (state_q == ST_RD_REQ);
   assign wr_valid_o = (state_q == ST_WR);
   assign wr_data_o  = rbuf_q;
   assign busy_o     = (state_q != ST_IDLE);
   assign done_o     = done_q;
   assign intr_o     = intr_q;

   // R2/R8: completion and interrupt never reported together
   assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && intr_o));
   // R4: read request held until accepted
   assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o && !rd_ready_i |=> rd_valid_o);
   // R4: write only after read data arrived
   assert_wr_after_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_valid_o) |-> $past(rd_data_valid_i));
   // R7: no memory traffic while idle
   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !rd_valid_o && !wr_valid_o);
   // R2: a stop always follows a write handshake
   assert_stop_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(wr_valid_o && wr_ready_i));
endmodule

// File: rtl/wordmove_engine.sv
module wordmove_engine #(
   parameter int HALF_W = 32,
   parameter int ADDR_W = 24,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ptr_we,
   input  logic [2*HALF_W-1:0] ptr_wdata,
   input  logic                cnt_we,
   input  logic [CNT_W-1:0]    cnt_wdata,
   input  logic                start,
   input  logic                irq,
   output logic [2*HALF_W-1:0] ptr_q,
   output logic [CNT_W-1:0]    cnt_q,
   output logic                busy,
   output logic                done,
   output logic                intr,
   output logic                rd_valid,
   input  logic                rd_ready,
   output logic [ADDR_W-1:0]   rd_addr,
   input  logic                rd_data_valid,
   input  logic [DATA_W-1:0]   rd_data,
   output logic                wr_valid,
   input  logic                wr_ready,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic [DATA_W-1:0]   wr_data
);
   localparam int WORD_BYTES = DATA_W / 8;
   localparam int N_HALVES   = 2;

   initial begin
      assert (DATA_W % 8 == 0) else $error("wordmove_engine: DATA_W not byte multiple");
      assert (ADDR_W <= HALF_W) else $error("wordmove_engine: ADDR_W exceeds HALF_W");
   end

   logic             adv;
   logic             save_en;
   logic [CNT_W-1:0] save_val;
   logic             host_ok;

   assign host_ok = !busy;

   genvar h;
   generate
      for (h = 0; h < N_HALVES; h++) begin : g_ptr
         wm_ptr_half #(.HALF_W(HALF_W), .ADDR_W(ADDR_W), .STEP(WORD_BYTES)) u_half (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (ptr_we && host_ok),
            .load_val (ptr_wdata[h*HALF_W +: ADDR_W]),
            .adv_en   (adv),
            .q        (ptr_q[h*HALF_W +: HALF_W])
         );
      end
      if (ADDR_W < HALF_W) begin : g_unused_hi
         logic [2*(HALF_W-ADDR_W)-1:0] ptr_hi_unused;
         assign ptr_hi_unused = {ptr_wdata[2*HALF_W-1 -: HALF_W-ADDR_W],
                                 ptr_wdata[HALF_W-1 -: HALF_W-ADDR_W]};
      end
   endgenerate

   wm_cnt_reg #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (cnt_we && host_ok),
      .load_val (cnt_wdata),
      .save_en  (save_en),
      .save_val (save_val),
      .q        (cnt_q)
   );

   wm_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .start_i         (start),
      .irq_i           (irq),
      .cnt_i           (cnt_q),
      .rd_valid_o      (rd_valid),
      .rd_ready_i      (rd_ready),
      .rd_data_valid_i (rd_data_valid),
      .rd_data_i       (rd_data),
      .wr_valid_o      (wr_valid),
      .wr_ready_i      (wr_ready),
      .wr_data_o       (wr_data),
      .adv_o           (adv),
      .save_en_o       (save_en),
      .save_val_o      (save_val),
      .busy_o          (busy),
      .done_o          (done),
      .intr_o          (intr)
   );

   assign rd_addr = ptr_q[ADDR_W-1:0];
   assign wr_addr = ptr_q[HALF_W +: ADDR_W];

   // R6: count register only changes on an interrupt stop while moving
   assert_cnt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cnt_q) || intr);
   // R7: zero count finishes at once
   assert_zero_cnt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && cnt_q == '0 |=> done && !busy);
   // R10: pointers frozen while busy unless a transfer completes
   assert_ptr_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !(wr_valid && wr_ready) |=> $stable(ptr_q));
   // R1: unused pointer bits read zero
   assert_ptr_hi_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q[HALF_W-1:ADDR_W] == '0 && ptr_q[2*HALF_W-1:HALF_W+ADDR_W] == '0);
endmodule

// File: tb/wordmove_engine_tb_top.sv
`timescale 1ns/1ps
module wordmove_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ptr_we = 1'b0;
   logic [63:0] ptr_wdata = '0;
   logic        cnt_we = 1'b0;
   logic [15:0] cnt_wdata = '0;
   logic        start = 1'b0;
   logic        irq = 1'b0;
   logic [63:0] ptr_q;
   logic [15:0] cnt_q;
   logic        busy, done, intr;
   logic        rd_valid, rd_ready, rd_data_valid;
   logic [23:0] rd_addr, wr_addr;
   logic [15:0] rd_data, wr_data;
   logic        wr_valid, wr_ready;

   always #2.5 clk = ~clk;

   wordmove_engine dut_i (
      .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
      .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .start(start), .irq(irq),
      .ptr_q(ptr_q), .cnt_q(cnt_q), .busy(busy), .done(done), .intr(intr),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
      .rd_data_valid(rd_data_valid), .rd_data(rd_data),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   // memory model: 512 words indexed by byte address bits 9:1
   logic [15:0] mem [512];
   int          rd_hs = 0;
   int          wr_hs = 0;
   int          cyc = 0;
   bit          stall = 0;
   logic        rdv_q = 1'b0;
   logic [15:0] rdat_q = '0;

   assign rd_ready      = stall ? (cyc[0] ^ cyc[2]) : 1'b1;
   assign wr_ready      = stall ? cyc[1] : 1'b1;
   assign rd_data_valid = rdv_q;
   assign rd_data       = rdat_q;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      rdv_q <= 1'b0;
      if (rd_valid && rd_ready) begin
         rdv_q  <= 1'b1;
         rdat_q <= mem[rd_addr[9:1]];
         rd_hs  <= rd_hs + 1;
      end
      if (wr_valid && wr_ready) begin
         mem[wr_addr[9:1]] <= wr_data;
         wr_hs <= wr_hs + 1;
      end
   end

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] pat(input int seed, input int i);
      return 16'((seed * 977 + i * 499) ^ 16'h5A5A);
   endfunction

   function automatic logic [23:0] a24(input logic [23:0] base, input int off);
      return base + 24'(off);
   endfunction

   task automatic fill(input logic [23:0] src, input logic [23:0] dst, input int n, input int seed);
      for (int i = 0; i < n; i++) begin
         mem[a24(src, 2*i)  >> 1 & 24'h1FF] = pat(seed, i);
         mem[a24(dst, 2*i)  >> 1 & 24'h1FF] = 16'hDEAD ^ 16'(i);
      end
   endtask

   task automatic load(input logic [23:0] src, input logic [23:0] dst, input int n);
      @(negedge clk);
      ptr_we = 1'b1; ptr_wdata = {8'h00, dst, 8'h00, src};
      cnt_we = 1'b1; cnt_wdata = 16'(n);
      @(negedge clk);
      ptr_we = 1'b0; cnt_we = 1'b0;
   endtask

   task automatic kick();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // returns 1 on done, 2 on intr, 0 on timeout
   task automatic wait_end(output int kind);
      kind = 0;
      for (int t = 0; t < 4000; t++) begin
         @(negedge clk);
         if (done && intr) begin kind = 3; return; end
         if (done) begin kind = 1; return; end
         if (intr) begin kind = 2; return; end
      end
   endtask

   task automatic check_dst(input string req, input logic [23:0] dst, input int n,
                            input int copied, input int seed);
      for (int i = 0; i < n; i++) begin
         chk(req, "dest word", mem[a24(dst, 2*i) >> 1 & 24'h1FF],
             i < copied ? pat(seed, i) : (16'hDEAD ^ 16'(i)));
      end
   endtask

   task automatic run_move(input logic [23:0] src, input logic [23:0] dst, input int n,
                           input bit stl, input int seed);
      int kind, r0, w0;
      stall = stl;
      fill(src, dst, n, seed);
      load(src, dst, n);
      r0 = rd_hs; w0 = wr_hs;
      kick();
      wait_end(kind);
      chk("R2", "end kind done", 64'(kind), 64'd1);
      chk("R2", "busy low at done", 64'(busy), 64'd0);
      chk("R4", "read count", 64'(rd_hs - r0), 64'(n));
      chk("R2", "write count", 64'(wr_hs - w0), 64'(n));
      chk("R5", "src pointer", 64'(ptr_q[23:0]), 64'(a24(src, 2*n)));
      chk("R5", "dst pointer", 64'(ptr_q[55:32]), 64'(a24(dst, 2*n)));
      chk("R6", "count unchanged", 64'(cnt_q), 64'(n));
      check_dst("R3", dst, n, n, seed);
      @(negedge clk);
      chk("R2", "done is one cycle", 64'(done), 64'd0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : main
      int kind, w0, r0, left, moved;
      for (int i = 0; i < 512; i++) mem[i] = 16'h0;
      repeat (4) @(negedge clk);
      chk("R2", "reset busy", 64'(busy), 64'd0);
      chk("R2", "reset done", 64'(done), 64'd0);
      chk("R1", "reset ptr", ptr_q, 64'd0);
      chk("R6", "reset count", 64'(cnt_q), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: high bits of each half are dropped
      @(negedge clk);
      ptr_we = 1'b1; ptr_wdata = 64'hAB12_3456_CD65_4321;
      @(negedge clk);
      ptr_we = 1'b0;
      chk("R1", "pointer masking", ptr_q, 64'h0012_3456_0065_4321);

      // sweep of lengths and stall patterns
      for (int s = 0; s < 2; s++) begin
         for (int n = 1; n <= 6; n++) begin
            run_move(24'h000040 + 24'(4*n), 24'h000200 + 24'(16*n), n, s[0], n + 10*s);
         end
      end

      // R5: source run crosses the top of the address space
      run_move(24'hFFFFFC, 24'h000100, 4, 1'b1, 77);

      // R7: zero count
      load(24'h000010, 24'h000020, 0);
      r0 = rd_hs; w0 = wr_hs;
      kick();
      chk("R7", "zero count done", 64'(done), 64'd1);
      chk("R7", "zero count busy", 64'(busy), 64'd0);
      repeat (3) @(negedge clk);
      chk("R7", "zero count no traffic", 64'((rd_hs - r0) + (wr_hs - w0)), 64'd0);
      chk("R7", "zero count ptr", ptr_q, 64'h0000_0020_0000_0010);

      // R10: start and register writes during a move are ignored
      stall = 1'b1;
      fill(24'h000060, 24'h000300, 6, 5);
      load(24'h000060, 24'h000300, 6);
      w0 = wr_hs;
      kick();
      repeat (3) @(negedge clk);
      ptr_we = 1'b1; ptr_wdata = 64'h0; cnt_we = 1'b1; cnt_wdata = 16'd9; start = 1'b1;
      @(negedge clk);
      ptr_we = 1'b0; cnt_we = 1'b0; start = 1'b0;
      wait_end(kind);
      chk("R10", "end kind", 64'(kind), 64'd1);
      chk("R10", "writes", 64'(wr_hs - w0), 64'd6);
      chk("R10", "count kept", 64'(cnt_q), 64'd6);
      chk("R10", "src ptr", 64'(ptr_q[23:0]), 64'h00006C);
      check_dst("R10", 24'h000300, 6, 6, 5);

      // R8/R9: irq held high, stops after each transfer, last one completes
      fill(24'h000080, 24'h000380, 4, 9);
      load(24'h000080, 24'h000380, 4);
      irq = 1'b1;
      moved = 0;
      for (int k = 0; k < 3; k++) begin
         w0 = wr_hs;
         kick();
         wait_end(kind);
         moved++;
         left = 4 - moved;
         chk("R8", "end kind intr", 64'(kind), 64'd2);
         chk("R8", "busy low", 64'(busy), 64'd0);
         chk("R8", "one transfer", 64'(wr_hs - w0), 64'd1);
         chk("R8", "remaining count", 64'(cnt_q), 64'(left));
         chk("R9", "src ptr", 64'(ptr_q[23:0]), 64'(24'h000080 + 24'(2*moved)));
         check_dst("R8", 24'h000380, 4, moved, 9);
         @(negedge clk);
         chk("R8", "intr is one cycle", 64'(intr), 64'd0);
      end
      kick();
      wait_end(kind);
      chk("R8", "last transfer completes", 64'(kind), 64'd1);
      chk("R6", "count after resumed finish", 64'(cnt_q), 64'd1);
      chk("R9", "dst ptr", 64'(ptr_q[55:32]), 64'h000388);
      check_dst("R9", 24'h000380, 4, 4, 9);
      irq = 1'b0;

      // R9: interrupt mid-run with irq raised later, then plain resume
      stall = 1'b0;
      fill(24'h0000A0, 24'h0003C0, 5, 3);
      load(24'h0000A0, 24'h0003C0, 5);
      kick();
      while (wr_hs == 0 || !(wr_valid)) @(negedge clk);
      irq = 1'b1;
      wait_end(kind);
      irq = 1'b0;
      chk("R8", "mid-run intr", 64'(kind), 64'd2);
      left = int'(cnt_q);
      moved = (int'(ptr_q[23:0]) - 32'hA0) / 2;
      chk("R9", "count + moved", 64'(left + moved), 64'd5);
      kick();
      wait_end(kind);
      chk("R9", "resume done", 64'(kind), 64'd1);
      chk("R9", "final src", 64'(ptr_q[23:0]), 64'h0000AA);
      check_dst("R9", 24'h0003C0, 5, 5, 3);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule